// File: doc/BRIEF.md
# Delta-Sigma ADC Readout Sequencer

This block drives a serial delta-sigma converter whose single output pin does two jobs: it falls to announce a finished conversion and then carries the result bits. The block passes that pin through a synchronizer and waits for the falling edge. It then generates the serial clock at once and shifts in the 24-bit two's complement result, most significant bit first. One more clock pulse follows the data bits and returns the pin high, so that the next ready edge is clean. No read is started from a timer. A conversion period that drifts by a few percent therefore changes only when the read begins.

The block also controls the converter's input selection. In alternating mode, each delivered sample flips the channel select and the gain select together: channel 0 uses the high gain of 128 and channel 1 uses unity gain. Each flip restarts the converter's fourth-order filter. The block then throws away the next three results and delivers the fourth, and it does the same after reset. Delivered samples leave as a one-cycle valid pulse with the data and a channel tag. A watchdog raises a one-cycle error pulse when no ready edge arrives within the nominal conversion time plus a 3% margin and a settling allowance.

Top module: `adc_readout_seq`

## Requirements
- R1: In reset and in the first cycle after it: `sclk`=0, `smp_valid`=0, `timeout_err`=0, `chan_sel`=0 (channel 0) and `gain_sel`=1 (gain 128).
- R2: A read starts only on a high-to-low transition of the synchronized `drdy_dout`. While the block waits for that edge, `sclk` stays low.
- R3: A read gives exactly DATA_W+1 `sclk` pulses, each high for SCLK_DIV clocks and then low for SCLK_DIV clocks. One bit is captured at the end of each of the first DATA_W high phases, MSB first.
- R4: The last pulse (number DATA_W+1) carries no data bit. It only returns `drdy_dout` high, and no pulse follows it before the next ready edge.
- R5: After reset and after every channel/gain change, the next SETTLE_N (3) results are discarded and the following result is delivered.
- R6: With `alt_en`=1, `chan_sel` toggles in the same cycle as each `smp_valid` pulse, and the select must have been held through the sample's conversion. `gain_sel` is always the inverse of `chan_sel` (1 = gain 128, 0 = gain 1). `smp_chan` gives the channel that the sample was converted on.
- R7: With `alt_en`=0, the channel is held and every result is delivered.
- R8: `smp_valid` is a one-cycle pulse. `smp_data` equals the 24 bits that were read, unchanged.
- R9: `timeout_err` pulses for one cycle once TIMEOUT = CONV_CYC + ceil(3% of CONV_CYC) + SETTLE_ALLOW clocks pass in the waiting state without a ready edge. The pulse repeats every TIMEOUT clocks while the edge stays absent.
- R10: Results are read correctly when the conversion period changes from one conversion to the next by up to ±3%.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| alt_en | input | 1 | 1 = alternate channel/gain after each delivered sample |
| drdy_dout | input | 1 | Shared ready/serial-data pin from the converter |
| sclk | output | 1 | Serial clock to the converter |
| chan_sel | output | 1 | Input channel select (0 or 1) |
| gain_sel | output | 1 | Gain select, 1 = 128, 0 = 1 |
| smp_valid | output | 1 | One-cycle sample strobe |
| smp_data | output | 24 | Sample, two's complement |
| smp_chan | output | 1 | Channel the sample belongs to |
| timeout_err | output | 1 | One-cycle watchdog pulse |

## Verification
The delivery of a sample and the channel/gain switch land in the same clock edge. The switch must take effect with the valid pulse, while the tag still names the channel the sample was taken on. The bench exercises this on every delivered sample in alternating mode. A behavioural converter stub records which select it saw during each conversion. At each valid pulse, the bench compares `smp_chan` with that recorded channel and compares `chan_sel`/`gain_sel` with the channel its reference model predicts next. The bench also stops the stub's conversions so that watchdog pulses can be checked for spacing against the waiting state.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    RX_WAIT = 2'd0,
    RX_HIGH = 2'd1,
    RX_LOW  = 2'd2
  } rx_state_t;
endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_in,
  output logic pin_s,
  output logic pin_fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-1:0], pin_in};
  end

  assign pin_s    = chain[STAGES-1];
  assign pin_fall = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/adc_serial_rx.sv
module adc_serial_rx
  import adc_seq_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int SCLK_DIV = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_s,
  input  logic              pin_fall,
  output logic              sclk,
  output logic              rx_idle,
  output logic              rx_done,
  output logic [DATA_W-1:0] rx_word
);
  localparam int DIV_W = $clog2(SCLK_DIV + 1);
  localparam int BIT_W = $clog2(DATA_W + 2);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCLK_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W);

  rx_state_t         state;
  logic [DIV_W-1:0]  div_cnt;
  logic [BIT_W-1:0]  bit_cnt;
  logic              sclk_r;
  logic              done_r;
  logic [DATA_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_WAIT;
      div_cnt <= '0;
      bit_cnt <= '0;
      sclk_r  <= 1'b0;
      done_r  <= 1'b0;
      shreg   <= '0;
    end else begin
      done_r <= 1'b0;
      case (state)
        RX_WAIT: if (pin_fall) begin
          state   <= RX_HIGH;
          sclk_r  <= 1'b1;
          div_cnt <= '0;
          bit_cnt <= '0;
        end
        RX_HIGH: if (div_cnt == DIV_LAST) begin
          div_cnt <= '0;
          sclk_r  <= 1'b0;
          state   <= RX_LOW;
          if (bit_cnt < BIT_LAST) shreg <= {shreg[DATA_W-2:0], pin_s};
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
        RX_LOW: if (div_cnt == DIV_LAST) begin
          div_cnt <= '0;
          if (bit_cnt == BIT_LAST) begin
            state  <= RX_WAIT;
            done_r <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            sclk_r  <= 1'b1;
            state   <= RX_HIGH;
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
        default: state <= RX_WAIT;
      endcase
    end
  end

  assign sclk    = sclk_r;
  assign rx_idle = (state == RX_WAIT);
  assign rx_done = done_r;
  assign rx_word = shreg;

  AST_SCLK_LOW_WAITING: assert property (@(posedge clk) disable iff (rst)
    (state == RX_WAIT) |-> !sclk_r); // R2
  AST_BIT_BOUND: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= BIT_LAST); // R3
  AST_SCLK_MIN_HIGH: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_r) |=> sclk_r); // R3
  AST_DONE_AFTER_LAST_LOW: assert property (@(posedge clk) disable iff (rst)
    done_r |-> ($past(state) == RX_LOW && $past(bit_cnt) == BIT_LAST)); // R4
endmodule

// File: rtl/adc_settle_ctrl.sv
module adc_settle_ctrl #(
  parameter int DATA_W   = 24,
  parameter int SETTLE_N = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alt_en,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_word,
  output logic              chan_sel,
  output logic              gain_sel,
  output logic              smp_valid,
  output logic [DATA_W-1:0] smp_data,
  output logic              smp_chan
);
  localparam int CNT_W = $clog2(SETTLE_N + 1);
  localparam logic [CNT_W-1:0] DISCARD_INIT = CNT_W'(SETTLE_N);

  logic              chan_r;
  logic [CNT_W-1:0]  discard;
  logic              valid_r;
  logic [DATA_W-1:0] data_r;
  logic              tag_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_r  <= 1'b0;
      discard <= DISCARD_INIT;
      valid_r <= 1'b0;
      data_r  <= '0;
      tag_r   <= 1'b0;
    end else begin
      valid_r <= 1'b0;
      if (rx_done) begin
        if (discard != '0) begin
          discard <= discard - 1'b1;
        end else begin
          valid_r <= 1'b1;
          data_r  <= rx_word;
          tag_r   <= chan_r;
          if (alt_en) begin
            chan_r  <= ~chan_r;
            discard <= DISCARD_INIT;
          end
        end
      end
    end
  end

  assign chan_sel  = chan_r;
  assign gain_sel  = ~chan_r;
  assign smp_valid = valid_r;
  assign smp_data  = data_r;
  assign smp_chan  = tag_r;

  AST_VALID_ONLY_SETTLED: assert property (@(posedge clk) disable iff (rst)
    valid_r |-> ($past(discard) == '0)); // R5
  AST_SWITCH_RELOADS: assert property (@(posedge clk) disable iff (rst)
    (valid_r && chan_r != tag_r) |-> (discard == DISCARD_INIT)); // R5
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    valid_r |=> !valid_r); // R8
  AST_CHAN_MOVES_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    !$stable(chan_r) |-> valid_r); // R6
  AST_HOLD_WHEN_FIXED: assert property (@(posedge clk) disable iff (rst)
    (valid_r && !$past(alt_en)) |-> (chan_r == tag_r)); // R7
endmodule

// File: rtl/adc_readout_seq.sv
module adc_readout_seq #(
  parameter int DATA_W       = 24,
  parameter int SCLK_DIV     = 6,
  parameter int SYNC_STAGES  = 2,
  parameter int SETTLE_N     = 3,
  parameter int CONV_CYC     = 1000,
  parameter int SETTLE_ALLOW = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alt_en,
  input  logic              drdy_dout,
  output logic              sclk,
  output logic              chan_sel,
  output logic              gain_sel,
  output logic              smp_valid,
  output logic [DATA_W-1:0] smp_data,
  output logic              smp_chan,
  output logic              timeout_err
);
  localparam int TIMEOUT = CONV_CYC + (CONV_CYC * 3 + 99) / 100 + SETTLE_ALLOW;
  localparam int WD_W    = $clog2(TIMEOUT + 1);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(TIMEOUT - 1);

  logic              pin_s, pin_fall;
  logic              rx_idle, rx_done;
  logic [DATA_W-1:0] rx_word;
  logic [WD_W-1:0]   wd_cnt;
  logic              wd_err;

  adc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_in(drdy_dout), .pin_s(pin_s), .pin_fall(pin_fall)
  );

  adc_serial_rx #(.DATA_W(DATA_W), .SCLK_DIV(SCLK_DIV)) u_rx (
    .clk(clk), .rst(rst), .pin_s(pin_s), .pin_fall(pin_fall), .sclk(sclk),
    .rx_idle(rx_idle), .rx_done(rx_done), .rx_word(rx_word)
  );

  adc_settle_ctrl #(.DATA_W(DATA_W), .SETTLE_N(SETTLE_N)) u_settle (
    .clk(clk), .rst(rst), .alt_en(alt_en), .rx_done(rx_done), .rx_word(rx_word),
    .chan_sel(chan_sel), .gain_sel(gain_sel), .smp_valid(smp_valid),
    .smp_data(smp_data), .smp_chan(smp_chan)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_cnt <= '0;
      wd_err <= 1'b0;
    end else begin
      wd_err <= 1'b0;
      if (!rx_idle || pin_fall) begin
        wd_cnt <= '0;
      end else if (wd_cnt == WD_LAST) begin
        wd_cnt <= '0;
        wd_err <= 1'b1;
      end else begin
        wd_cnt <= wd_cnt + 1'b1;
      end
    end
  end

  assign timeout_err = wd_err;

  AST_WD_ONLY_WAITING: assert property (@(posedge clk) disable iff (rst)
    timeout_err |-> $past(rx_idle)); // R9
  AST_WD_PULSE: assert property (@(posedge clk) disable iff (rst)
    timeout_err |=> !timeout_err); // R9
  AST_READ_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    ($rose(sclk) && $past(rx_idle)) |-> $past(pin_fall)); // R2
endmodule

// File: tb/sim_adc_readout_seq.sv
module sim_adc_readout_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 24;
  localparam int DIV        = 6;
  localparam int SETTLE     = 3;
  localparam int CONV       = 1000;
  localparam int ALLOW      = 100;
  localparam int TMO        = CONV + 30 + ALLOW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alt_en = 1'b1;
  logic pin = 1'b1;
  logic sclk, chan_sel, gain_sel, smp_valid, smp_chan, timeout_err;
  logic [DW-1:0] smp_data;

  int tests = 0, fails = 0;
  int n_valid = 0, n_to = 0;
  bit stall = 1'b0, allow_to = 1'b0, done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_readout_seq #(.DATA_W(DW), .SCLK_DIV(DIV), .SETTLE_N(SETTLE),
                    .CONV_CYC(CONV), .SETTLE_ALLOW(ALLOW)) u0 (
    .clk(clk), .rst(rst), .alt_en(alt_en), .drdy_dout(pin), .sclk(sclk),
    .chan_sel(chan_sel), .gain_sel(gain_sel), .smp_valid(smp_valid),
    .smp_data(smp_data), .smp_chan(smp_chan), .timeout_err(timeout_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] conv_val(input int k);
    case (k % 6)
      0: return 24'h7FFFFF;
      1: return 24'h800000;
      2: return 24'h000000;
      3: return 24'hFFFFFF;
      4: return DW'(k * 24'h01F3A7);
      default: return 24'hF00000 ^ DW'(k);
    endcase
  endfunction

  // reference model state
  logic [DW-1:0] q_data[$];
  logic          q_chan[$];
  logic          q_next[$];
  logic m_chan = 1'b0;
  int   m_disc = SETTLE;

  // behavioural converter stub
  int   timer = 0, period = CONV, kconv = 0, bitn = 0;
  bit   reading = 1'b0;
  logic last_chan = 1'b0, sclk_q = 1'b0;
  logic [DW-1:0] cur_val;

  always @(posedge clk) begin
    if (rst) begin
      timer <= 0; pin <= 1'b1; reading <= 1'b0; last_chan <= 1'b0; sclk_q <= 1'b0;
    end else begin
      sclk_q <= sclk;
      if (sclk && !sclk_q) begin
        chk(reading, "R2", "sclk pulse without pending result", 1, 0);
        if (reading) begin
          if (bitn < DW) pin <= cur_val[DW-1-bitn];
          else begin pin <= 1'b1; reading <= 1'b0; end
          bitn <= bitn + 1;
        end
      end
      if (chan_sel != last_chan) begin
        last_chan <= chan_sel;
        timer <= 0;
        pin <= 1'b1;
      end else if (stall) begin
        timer <= 0;
      end else if (timer >= period) begin
        chk(!reading, "R3", "previous read incomplete at next post", bitn, DW + 1);
        chk(chan_sel == m_chan, alt_en ? "R6" : "R7", "channel during conversion", chan_sel, m_chan);
        cur_val <= conv_val(kconv);
        pin <= 1'b0; reading <= 1'b1; bitn <= 0; timer <= 0;
        period <= CONV - 30 + ((kconv * 37) % 61); // R10 jitter +-3%
        if (m_disc > 0) m_disc = m_disc - 1;
        else begin
          q_data.push_back(conv_val(kconv));
          q_chan.push_back(m_chan);
          if (alt_en) begin m_chan = ~m_chan; m_disc = SETTLE; end
          q_next.push_back(m_chan);
        end
        kconv <= kconv + 1;
      end else begin
        timer <= timer + 1;
      end
    end
  end

  // per-clock comparison
  int hi_cnt = 0, cyc = 0, last_to = -1;
  logic prev_valid = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (sclk) hi_cnt++;
      else if (hi_cnt != 0) begin
        chk(hi_cnt == DIV, "R3", "sclk high width", hi_cnt, DIV);
        hi_cnt = 0;
      end
      if (prev_valid && smp_valid) chk(0, "R8", "valid longer than one cycle", 1, 0);
      if (smp_valid) begin
        n_valid++;
        if (q_data.size() == 0) chk(0, "R5", "valid for a discarded result", smp_data, 0);
        else begin
          logic [DW-1:0] ed; logic ec, en;
          ed = q_data.pop_front(); ec = q_chan.pop_front(); en = q_next.pop_front();
          chk(smp_data == ed, "R8", "sample data", smp_data, ed);
          chk(smp_chan == ec, "R6", "sample channel tag", smp_chan, ec);
          chk(chan_sel == en, "R6", "channel switch with valid", chan_sel, en);
          chk(gain_sel == ~chan_sel, "R6", "gain follows channel", gain_sel, ~chan_sel);
        end
      end
      if (timeout_err) begin
        n_to++;
        chk(allow_to, "R9", "timeout while conversions arrive", 1, 0);
        if (last_to >= 0) chk(cyc - last_to == TMO, "R9", "timeout spacing", cyc - last_to, TMO);
        last_to = cyc;
      end
    end
    prev_valid = smp_valid;
  end

  task automatic wait_valids(input int n);
    int target;
    target = n_valid + n;
    wait (n_valid >= target);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    if (!done_flag) begin
      chk(0, "R10", "run did not complete", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(sclk == 0, "R1", "sclk in reset", sclk, 0);
    chk(smp_valid == 0, "R1", "valid in reset", smp_valid, 0);
    chk(timeout_err == 0, "R1", "timeout in reset", timeout_err, 0);
    chk(chan_sel == 0, "R1", "channel in reset", chan_sel, 0);
    chk(gain_sel == 1, "R1", "gain in reset", gain_sel, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(sclk == 0 && smp_valid == 0, "R1", "outputs after reset", {sclk, smp_valid}, 0);
    // R5 R6 R10: alternating mode
    wait_valids(10);
    // R7: fixed channel
    alt_en = 1'b0;
    wait_valids(6);
    chk(chan_sel == smp_chan, "R7", "channel held", chan_sel, smp_chan);
    // R9: stop conversions
    allow_to = 1'b1; stall = 1'b1;
    repeat (3000) @(negedge clk);
    chk(n_to >= 2, "R9", "timeout pulses during stall", n_to, 2);
    stall = 1'b0;
    wait_valids(1);
    allow_to = 1'b0;
    // R6: back to alternating
    alt_en = 1'b1;
    wait_valids(5);
    chk(q_data.size() == 0, "R5", "pending expected samples", q_data.size(), 0);
    chk(n_valid == 22, "R8", "delivered sample count", n_valid, 22);
    done_flag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule